// File: doc/BRIEF.md
# Mode-Indexed Port Configuration Bank

This block keeps the configuration state of up to five 8-bit general-purpose I/O ports (index 0 to 4; index 1 is the port that also carries the wake-up and comparator registers). A 4-bit mode register decides what a single "configure port" strobe does. The strobe carries a port index and a data byte. Depending on the mode, the byte is stored as pin direction, pull-up enable, input-level select, Schmitt-trigger enable, wake-up enable or wake-up edge. Under two further modes the byte is swapped atomically with the wake-up pending register or the comparator configuration register, and the old contents come back on the exchange output.

Each port also has an output data latch, written through its own strobe. The latch is independent of direction, so software can preset a pin's level before turning the pin into an output. Wake-up pending bits are set by qualifying edges on the port-1 pin inputs. These inputs are assumed to be already synchronised to `clk`.

Top module: `pcfg_bank`

## Requirements
- R1: The mode register resets to 0xF and takes a new value on the edge after `mode_we`. A configure strobe in the same cycle as a mode write uses the previous mode.
- R2: Under mode 0xF a configure strobe stores the byte as the direction of port `cfg_port`. A direction bit of 1 means input and 0 means output. `pin_oe` is the inverse of direction, and every pin resets to input (`pin_oe` = 0).
- R3: Mode 0xE stores the byte as pull-up enable and mode 0xD stores it as input-level select, for every present port. Bit value 1 enables. Both reset to 0.
- R4: Mode 0xC stores the byte as Schmitt-trigger enable for ports 1 and up. For port 0 the strobe leaves `st_en` unchanged, and port 0's field stays 0.
- R5: Mode 0xB stores wake-up enable and mode 0xA stores wake-up edge, only when `cfg_port` is 1. Under these modes a strobe to any other port changes nothing.
- R6: Mode 0x9 with `cfg_port` = 1 swaps the byte with the wake-up pending register. `xchg_data` gets the old pending value and the pending register gets the byte, both on the same edge.
- R7: Mode 0x8 with `cfg_port` = 1 swaps the byte with the comparator configuration register in the same way. Under modes 0x9 and 0x8 a strobe to another port changes nothing.
- R8: A configure strobe under any mode from 0x0 to 0x7 changes no register.
- R9: A write on `lat_we` stores `lat_data` into the output latch of `lat_port`, and `pin_out` always shows the latch whatever the direction. A pin turned to output drives the preset latch value at once.
- R10: A configure or latch strobe whose port index is not below NPORTS is ignored.
- R11: A pending bit is set when an enabled port-1 pin sees an edge of the selected polarity: wake-up edge bit 0 selects rising and 1 selects falling. A set in the same cycle as a pending exchange overrides the written bit.
- R12: All configuration outputs change on the clock edge after the strobe. `xchg_data` is valid from that edge and holds until the next exchange; it resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_we | input | 1 | Load the mode register |
| mode_val | input | 4 | New mode value |
| cfg_stb | input | 1 | Configure-port strobe |
| cfg_port | input | 3 | Port index for the configure strobe |
| cfg_data | input | 8 | Configure data byte |
| xchg_data | output | 8 | Value returned by the last exchange |
| lat_we | input | 1 | Output latch write strobe |
| lat_port | input | 3 | Port index for the latch write |
| lat_data | input | 8 | Output latch data |
| wk_pin | input | 8 | Synchronised port-1 pin levels for wake-up detection |
| pin_oe | output | NPORTS*8 | Output enable per pin (1 = drive) |
| pin_out | output | NPORTS*8 | Output latch per pin |
| pull_en | output | NPORTS*8 | Pull-up enable per pin |
| lvl_sel | output | NPORTS*8 | Input level select per pin |
| st_en | output | NPORTS*8 | Schmitt-trigger enable per pin |
| wk_en | output | 8 | Port-1 wake-up enable |
| wk_edge | output | 8 | Port-1 wake-up edge select |
| wk_pend | output | 8 | Port-1 wake-up pending |
| cmp_cfg | output | 8 | Comparator configuration register |

## Verification
The in-line assertions check, on every cycle, the mode reset value and several other properties. A direction write lands on the following edge. Strobes under unused modes or to absent port indices leave the configuration outputs stable. A port-0 Schmitt write leaves `st_en` untouched. Each exchange returns the register's previous contents, and a wake-up set always survives a concurrent pending exchange. Other behaviour only shows in the bench's sequences, which compare every output field with a model after each step. These sequences cover the mode/strobe collision that uses the old mode, presetting a latch before the direction flips, the rising versus falling polarity choice per bit, and the order of repeated exchanges.

// File: rtl/pcfg_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the port configuration bank.
// Assumes 8-bit ports and a 4-bit mode register.
package pcfg_pkg;
    localparam int PORT_W = 8;
    localparam int PIDX_W = 3;
    localparam int MODE_W = 4;
    localparam int PORT_B = 1;

    typedef enum logic [MODE_W-1:0] {
        M_CMPX    = 4'h8,
        M_PENDX   = 4'h9,
        M_WKEDGE  = 4'hA,
        M_WKEN    = 4'hB,
        M_SCHMITT = 4'hC,
        M_LEVEL   = 4'hD,
        M_PULL    = 4'hE,
        M_DIR     = 4'hF
    } mode_e;

    typedef struct packed {
        logic dir;
        logic pull;
        logic lvl;
        logic st;
        logic wken;
        logic wked;
        logic xpend;
        logic xcmp;
    } cfg_op_t;
endpackage

// File: rtl/pcfg_mode_dec.sv
`timescale 1ns/1ps
// Mode register and strobe decoder.
// Holds the mode, turns a configure strobe into one operation flag, and
// produces one-hot port selects for configure and latch writes.
// Assumes NPORTS is between 2 and 5 so that port index 1 exists.
module pcfg_mode_dec
    import pcfg_pkg::*;
#(
    parameter int NPORTS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_val,
    input  logic              cfg_stb,
    input  logic [PIDX_W-1:0] cfg_port,
    input  logic              lat_we,
    input  logic [PIDX_W-1:0] lat_port,
    output cfg_op_t           op,
    output logic [NPORTS-1:0] port_hit,
    output logic [NPORTS-1:0] lat_hit,
    output logic [MODE_W-1:0] mode_o
);
    localparam logic [PIDX_W:0]   NP_L  = (PIDX_W+1)'(NPORTS);
    localparam logic [PIDX_W-1:0] PB_IX = PIDX_W'(PORT_B);

    mode_e mode_q;
    logic  cfg_ok;
    logic  lat_ok;
    logic  b_sel;

    // Mode register: loads on mode_we, resets to the direction mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= M_DIR;
        else if (mode_we) mode_q <= mode_e'(mode_val);
    end

    assign cfg_ok = cfg_stb && ({1'b0, cfg_port} < NP_L);
    assign lat_ok = lat_we && ({1'b0, lat_port} < NP_L);
    assign b_sel  = cfg_port == PB_IX;
    assign mode_o = mode_q;

    // Operation decode: one flag per mode; port-1-only modes need index 1.
    always_comb begin
        op = '0;
        if (cfg_ok) begin
            case (mode_q)
                M_DIR:     op.dir   = 1'b1;
                M_PULL:    op.pull  = 1'b1;
                M_LEVEL:   op.lvl   = 1'b1;
                M_SCHMITT: op.st    = 1'b1;
                M_WKEN:    op.wken  = b_sel;
                M_WKEDGE:  op.wked  = b_sel;
                M_PENDX:   op.xpend = b_sel;
                M_CMPX:    op.xcmp  = b_sel;
                default:   op       = '0;
            endcase
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NPORTS; gi++) begin : g_sel
            assign port_hit[gi] = cfg_ok && (cfg_port == PIDX_W'(gi));
            assign lat_hit[gi]  = lat_ok && (lat_port == PIDX_W'(gi));
        end
    endgenerate

    // R1: the first cycle after reset sees the direction mode
    assert_mode_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> mode_q == M_DIR);

    // R1: a mode write is visible on the next edge
    assert_mode_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> mode_o == $past(mode_val));
endmodule

// File: rtl/pcfg_port_slice.sv
`timescale 1ns/1ps
// Register slice of one 8-bit port: direction, pull-up, input level,
// Schmitt enable and output latch. Write enables arrive already qualified
// by port index. HAS_ST = 0 builds a port without Schmitt control.
module pcfg_port_slice
    import pcfg_pkg::*;
#(
    parameter int HAS_ST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_dir,
    input  logic              we_pull,
    input  logic              we_lvl,
    input  logic              we_st,
    input  logic              we_lat,
    input  logic [PORT_W-1:0] cfg_data,
    input  logic [PORT_W-1:0] lat_data,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] pull_q,
    output logic [PORT_W-1:0] lvl_q,
    output logic [PORT_W-1:0] st_q,
    output logic [PORT_W-1:0] lat_q
);
    localparam bit ST_ON = (HAS_ST != 0);

    // Direction: 1 = input; every pin starts as input.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (we_dir) dir_q <= cfg_data;
    end

    // Pull-up enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       pull_q <= '0;
        else if (we_pull) pull_q <= cfg_data;
    end

    // Input level select.
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl_q <= '0;
        else if (we_lvl) lvl_q <= cfg_data;
    end

    // Schmitt enable: writable only when the port has the feature.
    always_ff @(posedge clk) begin
        if (!rst_n)               st_q <= '0;
        else if (we_st && ST_ON)  st_q <= cfg_data;
    end

    // Output data latch, independent of direction.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (we_lat) lat_q <= lat_data;
    end

    // R2: a direction write is stored on the following edge
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_dir |=> dir_q == $past(cfg_data));

    // R9: a latch write does not disturb the direction
    assert_lat_indep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lat && !we_dir) |=> $stable(dir_q));
endmodule

// File: rtl/pcfg_wake.sv
`timescale 1ns/1ps
// Port-1 wake-up and comparator registers with atomic exchange.
// Pending bits are set by qualifying pin edges (edge bit 0 = rising,
// 1 = falling) on enabled pins; a set beats a concurrent exchange.
// Assumes wk_pin is already synchronised to clk.
module pcfg_wake
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] wk_pin,
    input  logic              we_en,
    input  logic              we_edge,
    input  logic              xc_pend,
    input  logic              xc_cmp,
    input  logic [PORT_W-1:0] cfg_data,
    output logic [PORT_W-1:0] en_q,
    output logic [PORT_W-1:0] edge_q,
    output logic [PORT_W-1:0] pend_q,
    output logic [PORT_W-1:0] cmp_q,
    output logic [PORT_W-1:0] xchg_q
);
    logic [PORT_W-1:0] prev_q;
    logic [PORT_W-1:0] rise_v;
    logic [PORT_W-1:0] fall_v;
    logic [PORT_W-1:0] set_v;
    logic [PORT_W-1:0] pend_base;

    // Previous pin level; tracks the pins during reset to avoid a false edge.
    always_ff @(posedge clk) begin
        prev_q <= wk_pin;
    end

    // Edge qualification per bit.
    always_comb begin
        rise_v    = wk_pin & ~prev_q;
        fall_v    = ~wk_pin & prev_q;
        set_v     = en_q & ((rise_v & ~edge_q) | (fall_v & edge_q));
        pend_base = xc_pend ? cfg_data : pend_q;
    end

    // Wake-up enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (we_en) en_q <= cfg_data;
    end

    // Wake-up edge select register.
    always_ff @(posedge clk) begin
        if (!rst_n)       edge_q <= '0;
        else if (we_edge) edge_q <= cfg_data;
    end

    // Pending register: exchange value or held value, plus new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_base | set_v;
    end

    // Comparator configuration register: written only by exchange.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (xc_cmp) cmp_q <= cfg_data;
    end

    // Exchange return value: the old contents of the swapped register.
    always_ff @(posedge clk) begin
        if (!rst_n)       xchg_q <= '0;
        else if (xc_pend) xchg_q <= pend_q;
        else if (xc_cmp)  xchg_q <= cmp_q;
    end

    // R6: a pending exchange returns the old pending value
    assert_xchg_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xc_pend |=> xchg_q == $past(pend_q));

    // R6: without a concurrent set, pending takes the written byte
    assert_pend_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xc_pend && set_v == '0) |=> pend_q == $past(cfg_data));

    // R7: a comparator exchange returns the old comparator value and stores the byte
    assert_xchg_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xc_cmp |=> (xchg_q == $past(cmp_q)) && (cmp_q == $past(cfg_data)));

    // R11: a qualifying edge always leaves its pending bit set
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((pend_q & $past(set_v)) == $past(set_v)));

    // R12: the exchange result holds while no exchange happens
    assert_xchg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!xc_pend && !xc_cmp) |=> $stable(xchg_q));
endmodule

// File: rtl/pcfg_bank.sv
`timescale 1ns/1ps
// Top of the mode-indexed port configuration bank.
// Combines the mode decoder, one register slice per port (port 0 without
// Schmitt control) and the port-1 wake/comparator registers.
// Assumes NPORTS in 3..5; pin vectors pack port i at bits [8i+7:8i].
module pcfg_bank
    import pcfg_pkg::*;
#(
    parameter int NPORTS = 5,
    localparam int PINS  = NPORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_val,
    input  logic              cfg_stb,
    input  logic [PIDX_W-1:0] cfg_port,
    input  logic [PORT_W-1:0] cfg_data,
    output logic [PORT_W-1:0] xchg_data,
    input  logic              lat_we,
    input  logic [PIDX_W-1:0] lat_port,
    input  logic [PORT_W-1:0] lat_data,
    input  logic [PORT_W-1:0] wk_pin,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pull_en,
    output logic [PINS-1:0]   lvl_sel,
    output logic [PINS-1:0]   st_en,
    output logic [PORT_W-1:0] wk_en,
    output logic [PORT_W-1:0] wk_edge,
    output logic [PORT_W-1:0] wk_pend,
    output logic [PORT_W-1:0] cmp_cfg
);
    localparam logic [PIDX_W:0] NP_L = (PIDX_W+1)'(NPORTS);

    cfg_op_t           op;
    logic [NPORTS-1:0] port_hit;
    logic [NPORTS-1:0] lat_hit;
    logic [MODE_W-1:0] mode_w;
    logic [PORT_W-1:0] dir_w [NPORTS];

    pcfg_mode_dec #(.NPORTS(NPORTS)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_we  (mode_we),
        .mode_val (mode_val),
        .cfg_stb  (cfg_stb),
        .cfg_port (cfg_port),
        .lat_we   (lat_we),
        .lat_port (lat_port),
        .op       (op),
        .port_hit (port_hit),
        .lat_hit  (lat_hit),
        .mode_o   (mode_w)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NPORTS; gp++) begin : g_port
            pcfg_port_slice #(.HAS_ST(gp != 0 ? 1 : 0)) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .we_dir   (op.dir  && port_hit[gp]),
                .we_pull  (op.pull && port_hit[gp]),
                .we_lvl   (op.lvl  && port_hit[gp]),
                .we_st    (op.st   && port_hit[gp]),
                .we_lat   (lat_hit[gp]),
                .cfg_data (cfg_data),
                .lat_data (lat_data),
                .dir_q    (dir_w[gp]),
                .pull_q   (pull_en[gp*PORT_W +: PORT_W]),
                .lvl_q    (lvl_sel[gp*PORT_W +: PORT_W]),
                .st_q     (st_en[gp*PORT_W +: PORT_W]),
                .lat_q    (pin_out[gp*PORT_W +: PORT_W])
            );
            assign pin_oe[gp*PORT_W +: PORT_W] = ~dir_w[gp];
        end
    endgenerate

    pcfg_wake u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .wk_pin   (wk_pin),
        .we_en    (op.wken),
        .we_edge  (op.wked),
        .xc_pend  (op.xpend),
        .xc_cmp   (op.xcmp),
        .cfg_data (cfg_data),
        .en_q     (wk_en),
        .edge_q   (wk_edge),
        .pend_q   (wk_pend),
        .cmp_q    (cmp_cfg),
        .xchg_q   (xchg_data)
    );

    // R8: strobes under unused modes leave every configuration output unchanged
    assert_low_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stb && mode_w < 4'h8) |=> $stable(pin_oe) && $stable(pull_en)
            && $stable(lvl_sel) && $stable(st_en) && $stable(wk_en)
            && $stable(wk_edge) && $stable(cmp_cfg) && $stable(xchg_data));

    // R4: a Schmitt write to port 0 changes no Schmitt bit
    assert_st_porta_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stb && mode_w == 4'hC && cfg_port == '0) |=> $stable(st_en));

    // R10: strobes to absent ports change no per-port configuration
    assert_port_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stb && ({1'b0, cfg_port} >= NP_L)) |=> $stable(pin_oe)
            && $stable(pull_en) && $stable(lvl_sel) && $stable(st_en)
            && $stable(cmp_cfg) && $stable(xchg_data));
endmodule

// File: tb/sim_pcfg_bank.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one step, updates a model built from
// the requirements and queues the expected value of every output field;
// the monitor compares them at the following falling edge.
module sim_pcfg_bank;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_we = 1'b0;
    logic [3:0]    mode_val = '0;
    logic          cfg_stb = 1'b0;
    logic [2:0]    cfg_port = '0;
    logic [7:0]    cfg_data = '0;
    logic [7:0]    xchg_data;
    logic          lat_we = 1'b0;
    logic [2:0]    lat_port = '0;
    logic [7:0]    lat_data = '0;
    logic [7:0]    wk_pin = '0;
    logic [NP*8-1:0] pin_oe, pin_out, pull_en, lvl_sel, st_en;
    logic [7:0]    wk_en, wk_edge, wk_pend, cmp_cfg;

    always #2.5 clk = ~clk;

    pcfg_bank #(.NPORTS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
        .cfg_stb(cfg_stb), .cfg_port(cfg_port), .cfg_data(cfg_data),
        .xchg_data(xchg_data), .lat_we(lat_we), .lat_port(lat_port),
        .lat_data(lat_data), .wk_pin(wk_pin), .pin_oe(pin_oe),
        .pin_out(pin_out), .pull_en(pull_en), .lvl_sel(lvl_sel),
        .st_en(st_en), .wk_en(wk_en), .wk_edge(wk_edge), .wk_pend(wk_pend),
        .cmp_cfg(cmp_cfg)
    );

    typedef struct {
        int        sel;
        int        idx;
        logic [7:0] exp;
        string     req;
    } item_t;

    item_t sbq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Requirement model
    logic [7:0] m_dir [NP];
    logic [7:0] m_pull[NP];
    logic [7:0] m_lvl [NP];
    logic [7:0] m_st  [NP];
    logic [7:0] m_lat [NP];
    logic [7:0] m_en, m_edge, m_pend, m_cmp, m_xchg, m_prev, cur_pins;
    logic [3:0] m_mode;

    task automatic model_reset();
        for (int i = 0; i < NP; i++) begin
            m_dir[i] = 8'hFF; m_pull[i] = 0; m_lvl[i] = 0; m_st[i] = 0; m_lat[i] = 0;
        end
        m_en = 0; m_edge = 0; m_pend = 0; m_cmp = 0; m_xchg = 0; m_prev = 0;
        cur_pins = 0; m_mode = 4'hF;
    endtask

    function automatic logic [7:0] get_field(int sel, int idx);
        case (sel)
            0: return pin_oe[idx*8 +: 8];
            1: return pin_out[idx*8 +: 8];
            2: return pull_en[idx*8 +: 8];
            3: return lvl_sel[idx*8 +: 8];
            4: return st_en[idx*8 +: 8];
            5: return wk_en;
            6: return wk_edge;
            7: return wk_pend;
            8: return cmp_cfg;
            default: return xchg_data;
        endcase
    endfunction

    task automatic push(int sel, int idx, logic [7:0] e, string req);
        item_t it;
        it.sel = sel; it.idx = idx; it.exp = e; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic push_all(string req);
        for (int i = 0; i < NP; i++) begin
            push(0, i, ~m_dir[i], req);
            push(1, i, m_lat[i], req);
            push(2, i, m_pull[i], req);
            push(3, i, m_lvl[i], req);
            push(4, i, m_st[i], req);
        end
        push(5, 0, m_en, req);
        push(6, 0, m_edge, req);
        push(7, 0, m_pend, req);
        push(8, 0, m_cmp, req);
        push(9, 0, m_xchg, req);
    endtask

    // Model of one configure strobe under the current (old) mode
    task automatic model_cfg(int p, logic [7:0] d);
        if (p < NP) begin
            case (m_mode)
                4'hF: m_dir[p] = d;
                4'hE: m_pull[p] = d;
                4'hD: m_lvl[p] = d;
                4'hC: if (p != 0) m_st[p] = d;
                4'hB: if (p == 1) m_en = d;
                4'hA: if (p == 1) m_edge = d;
                4'h9: if (p == 1) begin m_xchg = m_pend; m_pend = d; end
                4'h8: if (p == 1) begin m_xchg = m_cmp; m_cmp = d; end
                default: ;
            endcase
        end
    endtask

    // Driver: one cycle of stimulus, then model update and expectations
    task automatic step(bit dm, logic [3:0] mv, bit dc, int cp, logic [7:0] cd,
                        bit dl, int lp, logic [7:0] ld, logic [7:0] pins, string req);
        logic [7:0] set_v;
        @(negedge clk);
        mode_we = dm; mode_val = mv;
        cfg_stb = dc; cfg_port = cp[2:0]; cfg_data = cd;
        lat_we = dl; lat_port = lp[2:0]; lat_data = ld;
        wk_pin = pins;
        @(posedge clk);
        #1;
        mode_we = 1'b0; cfg_stb = 1'b0; lat_we = 1'b0;
        set_v = m_en & ((pins & ~m_prev & ~m_edge) | (~pins & m_prev & m_edge));
        m_prev = pins;
        cur_pins = pins;
        if (dc) model_cfg(cp, cd);
        m_pend = m_pend | set_v;
        if (dl && lp < NP) m_lat[lp] = ld;
        if (dm) m_mode = mv;
        push_all(req);
    endtask

    task automatic set_mode(logic [3:0] m, string req);
        step(1, m, 0, 0, 8'h00, 0, 0, 8'h00, cur_pins, req);
    endtask
    task automatic cfg(int p, logic [7:0] d, string req);
        step(0, 4'h0, 1, p, d, 0, 0, 8'h00, cur_pins, req);
    endtask
    task automatic lat(int p, logic [7:0] d, string req);
        step(0, 4'h0, 0, 0, 8'h00, 1, p, d, cur_pins, req);
    endtask
    task automatic pins(logic [7:0] v, string req);
        step(0, 4'h0, 0, 0, 8'h00, 0, 0, 8'h00, v, req);
    endtask

    // Monitor: pop and compare everything queued for this cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sbq.pop_front();
                act = get_field(it.sel, it.idx);
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s field=%0d port=%0d actual=%h expected=%h",
                             it.req, it.sel, it.idx, act, it.exp);
                end
            end
        end
    end

    // Stimulus
    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        push_all("R1 R2 R12 reset");

        // R2: default mode is direction
        cfg(0, 8'hF0, "R2 dir port0");
        // R9: preset latch, then turn port 1 to output
        lat(1, 8'hA5, "R9 latch preset");
        cfg(1, 8'h00, "R9 dir flip keeps latch");
        // R1: mode write and strobe together use the old mode
        step(1, 4'hE, 1, 2, 8'h33, 0, 0, 8'h00, cur_pins, "R1 same-cycle old mode");
        cfg(2, 8'h0C, "R3 pull port2");
        set_mode(4'hD, "R1 mode load");
        cfg(4, 8'h81, "R3 level port4");
        set_mode(4'hC, "R4 mode");
        cfg(0, 8'hFF, "R4 port0 ignored");
        cfg(3, 8'h5A, "R4 schmitt port3");
        set_mode(4'hB, "R5 mode");
        cfg(2, 8'hFF, "R5 other port ignored");
        cfg(1, 8'h0F, "R5 wake enable");
        set_mode(4'hA, "R5 mode");
        cfg(1, 8'h05, "R5 wake edge");
        set_mode(4'h5, "R8 mode");
        cfg(0, 8'h00, "R8 unused mode ignored");
        cfg(1, 8'h00, "R8 unused mode ignored");
        set_mode(4'hF, "R10 mode");
        cfg(5, 8'h00, "R10 port5 ignored");
        cfg(7, 8'h00, "R10 port7 ignored");
        lat(6, 8'h3C, "R10 latch port6 ignored");
        lat(4, 8'h3C, "R9 latch port4");
        // R11: rising sets bits with edge 0, falling sets bits with edge 1
        pins(8'hFF, "R11 rising edges");
        pins(8'h00, "R11 falling edges");
        set_mode(4'h9, "R6 mode");
        cfg(1, 8'h30, "R6 pending exchange");
        cfg(3, 8'h55, "R6 other port ignored");
        // R11: set beats exchange in the same cycle
        step(0, 4'h0, 1, 1, 8'h00, 0, 0, 8'h00, 8'hFF, "R11 set beats exchange");
        set_mode(4'h8, "R7 mode");
        cfg(1, 8'h77, "R7 comparator exchange");
        cfg(1, 8'h11, "R7 second exchange");
        cfg(3, 8'h99, "R7 other port ignored");
        set_mode(4'hF, "R12 mode");
        cfg(4, 8'h0F, "R12 xchg holds");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R12 actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule